// File: doc/BRIEF.md
# SIMD Four-Element Shuffle Unit

This block rearranges the elements of a 128-bit vector in aligned groups of four. An 8-bit immediate holds four 2-bit selectors. Within each group, output element i takes the source element of that group chosen by the selector at position i mod 4. The same selector pattern is applied to every group in the vector.

A 2-bit format field sets the element width. Code 0 selects bytes (16 elements), code 1 selects halfwords (8 elements) and code 2 selects words (4 elements). Code 3 would select doublewords. That width has only two elements, so it cannot form a group of four: it is rejected as a reserved instruction and produces no result.

The unit has one pipeline register. A request presented with the input strobe appears at the outputs on the next clock edge. The whole source vector is captured before the registered result changes, so a caller can feed the previous result back as the next source. Register file access and writeback are done by the surrounding pipeline.

Top module: `quad_shuffle_unit`

## Requirements
- R1: While reset is asserted and right after it, `out_valid` and `out_illegal` are 0 and `out_vec` is all zeros.
- R2: With format 0 (bytes, byte e at bits [8e+7:8e]), output byte e equals source byte 4*floor(e/4) + imm[2(e mod 4)+1 : 2(e mod 4)].
- R3: With format 1 (halfwords, halfword e at bits [16e+15:16e]), output halfword e follows the same index rule over 8 elements.
- R4: With format 2 (words, word e at bits [32e+31:32e]), output word e follows the same index rule over 4 elements.
- R5: A request with format 3 raises `out_illegal` one cycle later with `out_valid` low, and `out_vec` keeps its previous value.
- R6: A legal request gives `out_valid` high exactly one cycle after `in_valid`. In a cycle that follows no request, both flags are low and `out_vec` is unchanged.
- R7: Immediate 0xE4 (selectors 3,2,1,0 from the top pair down) reproduces the source vector unchanged for formats 0, 1 and 2.
- R8: `out_valid` and `out_illegal` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| in_fmt | input | 2 | Element size: 0 byte, 1 halfword, 2 word, 3 doubleword (reserved) |
| in_imm | input | 8 | Four 2-bit selectors; bits [2k+1:2k] serve lane k of each group |
| in_vec | input | 128 | Source vector |
| out_valid | output | 1 | Registered result is valid |
| out_illegal | output | 1 | Previous request had the reserved format |
| out_vec | output | 128 | Registered permuted vector |

## Verification
Each legal format is driven with the following immediates:

- **0xE4** is the identity. A failure here points to wrong wiring rather than wrong selection.
- **0x1B** reverses each group, and **0x00** broadcasts lane 0 to the whole group. These two expose a selector pair that is swapped between lanes.
- **Random immediates on random data** catch an element-width mix-up between formats, because a byte-indexed gather differs from a word-indexed one.

Requests with the doubleword code are placed between legal ones to confirm that the last result is held. Idle gaps and back-to-back streaming separate a latency error from a hold error.

// File: rtl/qshuf_pkg.sv
`timescale 1ns/1ps
package qshuf_pkg;

  typedef enum logic [1:0] {
    FMT_BYTE  = 2'd0,
    FMT_HALF  = 2'd1,
    FMT_WORD  = 2'd2,
    FMT_DWORD = 2'd3
  } qshuf_fmt_e;

  localparam int unsigned QUAD     = 4;
  localparam int unsigned SEL_W    = 2;
  localparam int unsigned IMM_W    = QUAD * SEL_W;
  localparam int unsigned NUM_FMT  = 3;
  localparam int unsigned BASE_EW  = 8;

  // element width in bits for a legal format code
  function automatic int unsigned fmt_elem_w(int unsigned f);
    return BASE_EW << f;
  endfunction

  // source element index feeding destination element dst
  function automatic int unsigned src_index(int unsigned dst, logic [IMM_W-1:0] imm);
    logic [SEL_W-1:0] sel;
    sel = imm[SEL_W*(dst % QUAD) +: SEL_W];
    return (dst - (dst % QUAD)) + 32'(sel);
  endfunction

endpackage

// File: rtl/qshuf_elem_perm.sv
`timescale 1ns/1ps
module qshuf_elem_perm
  import qshuf_pkg::*;
#(
  parameter int unsigned VEC_W  = 128,
  parameter int unsigned ELEM_W = 8
) (
  input  logic [VEC_W-1:0] src_vec,
  input  logic [IMM_W-1:0] imm,
  output logic [VEC_W-1:0] dst_vec
);

  localparam int unsigned NUM_EL = VEC_W / ELEM_W;
  localparam int unsigned IDX_W  = $clog2(NUM_EL);

  logic [ELEM_W-1:0] src_el [NUM_EL];
  logic [IDX_W-1:0]  pick   [NUM_EL];

  for (genvar e = 0; e < NUM_EL; e++) begin : g_el
    assign src_el[e] = src_vec[e*ELEM_W +: ELEM_W];
    // index = group base + lane selector
    assign pick[e] = IDX_W'(src_index(e, imm));
    assign dst_vec[e*ELEM_W +: ELEM_W] = src_el[pick[e]];
  end

endmodule

// File: rtl/qshuf_fmt_select.sv
`timescale 1ns/1ps
module qshuf_fmt_select
  import qshuf_pkg::*;
#(
  parameter int unsigned VEC_W = 128
) (
  input  logic [NUM_FMT-1:0][VEC_W-1:0] cand,
  input  qshuf_fmt_e                     fmt,
  output logic [VEC_W-1:0]               pick_vec,
  output logic                           illegal
);

  always_comb begin
    illegal  = 1'b0;
    pick_vec = '0;
    case (fmt)
      FMT_BYTE: pick_vec = cand[0];
      FMT_HALF: pick_vec = cand[1];
      FMT_WORD: pick_vec = cand[2];
      default:  illegal  = 1'b1;
    endcase
  end

endmodule

// File: rtl/quad_shuffle_unit.sv
`timescale 1ns/1ps
module quad_shuffle_unit
  import qshuf_pkg::*;
#(
  parameter int unsigned VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       in_fmt,
  input  logic [IMM_W-1:0] in_imm,
  input  logic [VEC_W-1:0] in_vec,
  output logic             out_valid,
  output logic             out_illegal,
  output logic [VEC_W-1:0] out_vec
);

  qshuf_fmt_e                    fmt_q;
  logic [NUM_FMT-1:0][VEC_W-1:0] cand;
  logic [VEC_W-1:0]              pick_vec;
  logic                          fmt_illegal;
  logic                          accept_legal;
  logic                          accept_illegal;

  assign fmt_q = qshuf_fmt_e'(in_fmt);

  // one gather network per legal element width
  for (genvar f = 0; f < NUM_FMT; f++) begin : g_fmt
    qshuf_elem_perm #(
      .VEC_W  (VEC_W),
      .ELEM_W (fmt_elem_w(f))
    ) u_perm (
      .src_vec (in_vec),
      .imm     (in_imm),
      .dst_vec (cand[f])
    );
  end

  qshuf_fmt_select #(.VEC_W(VEC_W)) u_sel (
    .cand     (cand),
    .fmt      (fmt_q),
    .pick_vec (pick_vec),
    .illegal  (fmt_illegal)
  );

  assign accept_legal   = in_valid & ~fmt_illegal;
  assign accept_illegal = in_valid &  fmt_illegal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
      out_vec     <= '0;
    end else begin
      out_valid   <= accept_legal;
      out_illegal <= accept_illegal;
      if (accept_legal) out_vec <= pick_vec;
    end
  end

  AST_LEGAL_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_fmt != 2'd3) |=> (out_valid && !out_illegal)); // R6
  AST_ILLEGAL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_fmt == 2'd3) |=> (out_illegal && !out_valid)); // R5
  AST_ILLEGAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_fmt == 2'd3) |=> $stable(out_vec)); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !out_illegal)); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_vec)); // R6
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && out_illegal)); // R8
  AST_IDENTITY_IMM: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_imm == 8'hE4 && in_fmt != 2'd3) |-> (pick_vec == in_vec)); // R7

endmodule

// File: tb/quad_shuffle_unit_tb_top.sv
`timescale 1ns/1ps
module quad_shuffle_unit_tb_top;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [1:0]   in_fmt;
  logic [7:0]   in_imm;
  logic [127:0] in_vec;
  logic         out_valid;
  logic         out_illegal;
  logic [127:0] out_vec;

  int checks = 0;
  int errors = 0;

  // behavioural model state
  logic [127:0] m_vec;
  logic         m_valid;
  logic         m_ill;

  always #5 clk = ~clk; // 100 MHz

  quad_shuffle_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_fmt(in_fmt),
    .in_imm(in_imm), .in_vec(in_vec), .out_valid(out_valid),
    .out_illegal(out_illegal), .out_vec(out_vec)
  );

  function automatic logic [127:0] ref_shf(logic [127:0] v, int f, logic [7:0] imm);
    int nbytes;
    int n;
    int j;
    logic [127:0] r;
    nbytes = 1 << f;
    n = 16 / nbytes;
    r = v;
    for (int i = 0; i < n; i++) begin
      j = (i / 4) * 4 + ((int'(imm) >> (2 * (i % 4))) & 3);
      for (int b = 0; b < nbytes; b++)
        r[(i*nbytes + b)*8 +: 8] = v[(j*nbytes + b)*8 +: 8];
    end
    return r;
  endfunction

  function automatic logic [127:0] rnd_vec();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string fmt_tag(logic [1:0] f, logic [7:0] imm);
    if (f == 2'd3) return "R5";
    if (imm == 8'hE4) return "R7";
    case (f)
      2'd0: return "R2";
      2'd1: return "R3";
      default: return "R4";
    endcase
  endfunction

  // called at a falling edge; compares at the next falling edge
  task automatic step(input logic v, input logic [1:0] f, input logic [7:0] imm,
                      input logic [127:0] vec);
    string vt;
    string ft;
    in_valid = v; in_fmt = f; in_imm = imm; in_vec = vec;
    if (v && f != 2'd3) begin
      m_vec = ref_shf(vec, int'(f), imm); m_valid = 1'b1; m_ill = 1'b0;
    end else if (v) begin
      m_valid = 1'b0; m_ill = 1'b1;
    end else begin
      m_valid = 1'b0; m_ill = 1'b0;
    end
    vt = v ? fmt_tag(f, imm) : "R6";
    ft = (v && f == 2'd3) ? "R5" : "R6";
    @(negedge clk);
    check(ft, {127'd0, out_valid}, {127'd0, m_valid});
    check(ft, {127'd0, out_illegal}, {127'd0, m_ill});
    check(vt, out_vec, m_vec);
    check("R8", {127'd0, out_valid & out_illegal}, 128'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [127:0] v;
    rst_n = 1'b0; in_valid = 1'b1; in_fmt = 2'd0; in_imm = 8'h1B;
    in_vec = {4{32'hDEADBEEF}};
    m_vec = '0; m_valid = 1'b0; m_ill = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", {127'd0, out_valid}, 128'd0);
    check("R1", {127'd0, out_illegal}, 128'd0);
    check("R1", out_vec, 128'd0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", out_vec, 128'd0);

    // identity for every legal format (R7)
    for (int f = 0; f < 3; f++) step(1'b1, 2'(f), 8'hE4, rnd_vec());
    // directed patterns per format: reverse, broadcast, rotate
    v = 128'h0F0E0D0C0B0A09080706050403020100;
    for (int f = 0; f < 3; f++) begin
      step(1'b1, 2'(f), 8'h1B, v);
      step(1'b1, 2'(f), 8'h00, v);
      step(1'b1, 2'(f), 8'h39, v);
    end
    // reserved format holds the previous result (R5)
    step(1'b1, 2'd0, 8'h4E, rnd_vec());
    step(1'b1, 2'd3, 8'hE4, rnd_vec());
    step(1'b1, 2'd3, 8'h00, rnd_vec());
    // idle gap keeps the result (R6)
    step(1'b0, 2'd1, 8'h1B, rnd_vec());
    step(1'b0, 2'd2, 8'h00, rnd_vec());
    // feed result back as source
    step(1'b1, 2'd2, 8'h1B, out_vec);
    step(1'b1, 2'd2, 8'h1B, out_vec);
    // random traffic across all formats and idle cycles
    for (int n = 0; n < 400; n++)
      step(($urandom % 5) != 0, 2'($urandom), 8'($urandom), rnd_vec());

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule